// File: doc/BRIEF.md
# Per-Pin Input Debounce Filter

This block cleans up one general-purpose input pin before the pin level reaches interrupt or status logic. The raw pin first passes through a two-stage synchroniser. A filter then decides when the cleaned level may follow it. The filter's timing comes from a slow time base of about 32.768 kHz, which arrives as a one-cycle enable pulse in the block's own clock domain. Each accepted enable pulse is one slow clock.

The debounce window is built from two settings. One is a tick length, picked by a 2-bit unit select. The other is a 4-bit repeat count. Four filter behaviours are available:
- Bypass, where the synchronised level goes straight to the output.
- Hold-low, where low pulses get through at once and rises are filtered.
- Hold-high, the mirror of hold-low.
- Strict, where changes in both directions must survive the full window.

Hold-low suits an active-high level interrupt, and hold-high suits an active-low one.

Top module: `pin_debounce`

## Requirements
- R1: The raw input reaches the filter through two flip-flops. In bypass mode, a change of `pin_raw` shows on `pin_clean` after exactly three rising clock edges.
- R2: With `flt_mode` = 2'b00 (bypass), no window is applied. `pin_clean` follows the synchronised level in every mode 00 case, whatever the other settings are.
- R3: `{unit_large, unit_fine}` selects the tick length in slow-clock pulses: 00 gives 2, 01 gives 8, 10 gives 512 and 11 gives 2048.
- R4: The window is `win_count` times the selected tick length. A `win_count` of 0 behaves as 1.
- R5: With `flt_mode` = 2'b11 (strict), a rise or a fall reaches `pin_clean` only after the new level has been held for the whole window.
- R6: Any change of the synchronised input while a change is pending restarts the window. A pulse shorter than the window never reaches the output.
- R7: With `flt_mode` = 2'b01 (hold-low), a fall reaches the output one cycle after the synchroniser. A rise is filtered by the window.
- R8: With `flt_mode` = 2'b10 (hold-high), a rise reaches the output one cycle after the synchroniser. A fall is filtered by the window.
- R9: While `rst` is high, `pin_clean` is 0, and the synchroniser and counters are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_en | input | 1 | One-cycle pulse per slow time-base period |
| pin_raw | input | 1 | Asynchronous pin level |
| flt_mode | input | 2 | 00 bypass, 01 hold-low, 10 hold-high, 11 strict |
| unit_large | input | 1 | Tick select, high bit |
| unit_fine | input | 1 | Tick select, low bit |
| win_count | input | CNT_W | Ticks per window (0 treated as 1) |
| pin_clean | output | 1 | Filtered, registered pin level |

## Verification
The hardest situation to reach is a glitch that arrives partway through a window. In that case the restart must discard the partial count. The output therefore flips only one full window after the last edge, not after the first. The stimulus holds a new level for more than half a window, drops it briefly, and then raises it again. Checks placed relative to the last edge separate a correct restart from an accumulating count. The hold modes get a similar short opposite pulse. That pulse must pass at once and then be held by the filter on its way back.

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;
  typedef enum logic [1:0] {
    FM_BYPASS    = 2'b00,
    FM_HOLD_LOW  = 2'b01,
    FM_HOLD_HIGH = 2'b10,
    FM_STRICT    = 2'b11
  } fmode_e;
endpackage

// File: rtl/dbnc_sync.sv
module dbnc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d_in};
  end

  assign q_out = chain[STAGES-1];
endmodule

// File: rtl/dbnc_prescale.sv
module dbnc_prescale #(
  parameter int UNIT_T0 = 2,
  parameter int UNIT_T1 = 8,
  parameter int UNIT_T2 = 512,
  parameter int UNIT_T3 = 2048
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       slow_en,
  input  logic       clear,
  input  logic [1:0] sel,
  output logic       unit_tick
);
  localparam int PW = $clog2(UNIT_T3 + 1);

  logic [PW-1:0] last_idx;
  logic [PW-1:0] cnt;
  logic          at_end;

  always_comb begin
    case (sel)
      2'b00:   last_idx = PW'(UNIT_T0 - 1);
      2'b01:   last_idx = PW'(UNIT_T1 - 1);
      2'b10:   last_idx = PW'(UNIT_T2 - 1);
      default: last_idx = PW'(UNIT_T3 - 1);
    endcase
  end

  assign at_end    = (cnt >= last_idx);
  assign unit_tick = slow_en && !clear && at_end;

  always_ff @(posedge clk) begin
    if (rst || clear)  cnt <= '0;
    else if (slow_en)  cnt <= at_end ? '0 : cnt + 1'b1;
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= PW'(UNIT_T3 - 1));

  // R6
  clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
    clear |=> (cnt == '0));
endmodule

// File: rtl/dbnc_core.sv
module dbnc_core
  import dbnc_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s_lvl,
  input  logic             unit_tick,
  input  fmode_e           mode,
  input  logic [CNT_W-1:0] count,
  output logic             clear,
  output logic             filt
);
  logic             s_d;
  logic [CNT_W-1:0] win_cnt;
  logic [CNT_W-1:0] target_m1;
  logic             pending;
  logic             moved;
  logic             fast_pass;

  assign target_m1 = (count == '0) ? '0 : count - 1'b1;
  assign pending   = (s_lvl != filt);
  assign moved     = (s_lvl != s_d);
  assign fast_pass = ((mode == FM_HOLD_LOW)  && !s_lvl) ||
                     ((mode == FM_HOLD_HIGH) &&  s_lvl);
  assign clear     = (mode == FM_BYPASS) || fast_pass || !pending || moved;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_d     <= 1'b0;
      filt    <= 1'b0;
      win_cnt <= '0;
    end else begin
      s_d <= s_lvl;
      if (mode == FM_BYPASS || fast_pass) begin
        filt    <= s_lvl;
        win_cnt <= '0;
      end else if (clear) begin
        win_cnt <= '0;
      end else if (unit_tick) begin
        if (win_cnt >= target_m1) begin
          filt    <= s_lvl;
          win_cnt <= '0;
        end else begin
          win_cnt <= win_cnt + 1'b1;
        end
      end
    end
  end

  // R4
  win_bound_chk: assert property (@(posedge clk) disable iff (rst)
    win_cnt < {CNT_W{1'b1}});

  // R2
  follow_only_chk: assert property (@(posedge clk) disable iff (rst)
    (filt != $past(filt)) |-> (filt == $past(s_lvl)));

  // R5
  strict_stable_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(mode) == FM_STRICT && filt != $past(filt))
      |-> ($past(s_lvl) == $past(s_lvl, 2)));

  // R7
  hold_low_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == FM_HOLD_LOW && !s_lvl) |=> !filt);

  // R8
  hold_high_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == FM_HOLD_HIGH && s_lvl) |=> filt);
endmodule

// File: rtl/pin_debounce.sv
module pin_debounce
  import dbnc_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int UNIT_T0 = 2,
  parameter int UNIT_T1 = 8,
  parameter int UNIT_T2 = 512,
  parameter int UNIT_T3 = 2048
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             slow_en,
  input  logic             pin_raw,
  input  logic [1:0]       flt_mode,
  input  logic             unit_large,
  input  logic             unit_fine,
  input  logic [CNT_W-1:0] win_count,
  output logic             pin_clean
);
  logic   s_lvl;
  logic   unit_tick;
  logic   clear;
  fmode_e mode;

  assign mode = fmode_e'(flt_mode);

  dbnc_sync #(.STAGES(2)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  (pin_raw),
    .q_out (s_lvl)
  );

  dbnc_prescale #(
    .UNIT_T0 (UNIT_T0),
    .UNIT_T1 (UNIT_T1),
    .UNIT_T2 (UNIT_T2),
    .UNIT_T3 (UNIT_T3)
  ) u_prescale (
    .clk       (clk),
    .rst       (rst),
    .slow_en   (slow_en),
    .clear     (clear),
    .sel       ({unit_large, unit_fine}),
    .unit_tick (unit_tick)
  );

  dbnc_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .s_lvl     (s_lvl),
    .unit_tick (unit_tick),
    .mode      (mode),
    .count     (win_count),
    .clear     (clear),
    .filt      (pin_clean)
  );

  // R2
  bypass_track_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(flt_mode) == 2'b00) |-> (pin_clean == $past(s_lvl)));

  // R9
  reset_low_chk: assert property (@(posedge clk)
    $past(rst) |-> !pin_clean);
endmodule

// File: tb/pin_debounce_bench.sv
module pin_debounce_bench;
  localparam int T = 4;  // clocks between slow enable pulses

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       slow_en = 1'b0;
  logic       pin_raw = 1'b0;
  logic [1:0] flt_mode = 2'b00;
  logic       unit_large = 1'b0;
  logic       unit_fine = 1'b0;
  logic [3:0] win_count = 4'd0;
  logic       pin_clean;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pin_debounce u_pin_debounce (
    .clk        (clk),
    .rst        (rst),
    .slow_en    (slow_en),
    .pin_raw    (pin_raw),
    .flt_mode   (flt_mode),
    .unit_large (unit_large),
    .unit_fine  (unit_fine),
    .win_count  (win_count),
    .pin_clean  (pin_clean)
  );

  // slow time base: one-cycle pulse every T clocks, changed mid-cycle
  initial begin
    #2;
    forever begin
      repeat (T - 1) @(posedge clk);
      #4 slow_en = 1'b1;
      @(posedge clk);
      #4 slow_en = 1'b0;
    end
  end

  // fields: req[3:0] mode[1:0] sel[1:0] cnt[3:0] from to imm
  localparam int NV = 11;
  localparam logic [14:0] VEC [NV] = '{
    {4'd3, 2'b11, 2'b00, 4'd3,  1'b0, 1'b1, 1'b0}, // R3 tick 2
    {4'd5, 2'b11, 2'b01, 4'd5,  1'b1, 1'b0, 1'b0}, // R5 strict fall
    {4'd4, 2'b11, 2'b01, 4'd0,  1'b0, 1'b1, 1'b0}, // R4 count 0 as 1
    {4'd4, 2'b11, 2'b01, 4'd15, 1'b0, 1'b1, 1'b0}, // R4 max count
    {4'd3, 2'b11, 2'b10, 4'd2,  1'b1, 1'b0, 1'b0}, // R3 tick 512
    {4'd3, 2'b11, 2'b11, 4'd1,  1'b0, 1'b1, 1'b0}, // R3 tick 2048
    {4'd7, 2'b01, 2'b01, 4'd4,  1'b1, 1'b0, 1'b1}, // R7 fall passes
    {4'd7, 2'b01, 2'b01, 4'd4,  1'b0, 1'b1, 1'b0}, // R7 rise filtered
    {4'd8, 2'b10, 2'b01, 4'd4,  1'b0, 1'b1, 1'b1}, // R8 rise passes
    {4'd8, 2'b10, 2'b01, 4'd4,  1'b1, 1'b0, 1'b0}, // R8 fall filtered
    {4'd2, 2'b00, 2'b11, 4'd15, 1'b0, 1'b1, 1'b1}  // R2 bypass
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #4;
  endtask

  task automatic check(input logic act, input logic exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic settle(input logic lvl);
    flt_mode = 2'b00;
    pin_raw  = lvl;
    step(6);
  endtask

  function automatic int unit_len(input logic [1:0] s);
    case (s)
      2'b00:   return 2;
      2'b01:   return 8;
      2'b10:   return 512;
      default: return 2048;
    endcase
  endfunction

  initial begin
    step(1);
    pin_raw = 1'b1;
    step(4);
    // R9: held in reset with pin high, output stays low
    check(pin_clean, 1'b0, "R9 reset");
    rst = 1'b0;
    pin_raw = 1'b0;
    step(6);
    check(pin_clean, 1'b0, "R9 after reset");

    // R1: exact three-edge latency in bypass
    pin_raw = 1'b1;
    step(2);
    check(pin_clean, 1'b0, "R1 two edges");
    step(1);
    check(pin_clean, 1'b1, "R1 three edges");

    for (int i = 0; i < NV; i++) begin
      logic [3:0] rq;
      logic [1:0] md, sl;
      logic [3:0] cn;
      logic       fr, to, im;
      int         nt;
      string      tag;
      {rq, md, sl, cn, fr, to, im} = VEC[i];
      tag = $sformatf("R%0d vec %0d", rq, i);
      settle(fr);
      flt_mode = md;
      {unit_large, unit_fine} = sl;
      win_count = cn;
      step(2);
      pin_raw = to;
      if (im) begin
        step(4);
        check(pin_clean, to, tag);
      end else begin
        nt = ((cn == 0) ? 1 : int'(cn)) * unit_len(sl);
        if (nt >= 4) begin
          step(T * nt - 8);
          check(pin_clean, fr, {tag, " early"});
          step(16);
        end else begin
          step(T * nt + 8);
        end
        check(pin_clean, to, {tag, " late"});
      end
    end

    // R6: restart on a short drop inside the window (window 32 ticks)
    settle(1'b0);
    flt_mode = 2'b11;
    {unit_large, unit_fine} = 2'b01;
    win_count = 4'd4;
    step(2);
    pin_raw = 1'b1;
    step(80);
    pin_raw = 1'b0;
    step(8);
    check(pin_clean, 1'b0, "R6 drop");
    pin_raw = 1'b1;
    step(T * 32 - 8);
    check(pin_clean, 1'b0, "R6 restart early");
    step(16);
    check(pin_clean, 1'b1, "R6 restart late");

    // R6: pulse shorter than the window never appears
    pin_raw = 1'b0;
    step(40);
    pin_raw = 1'b1;
    step(T * 32 + 16);
    check(pin_clean, 1'b1, "R6 short pulse");

    // R7: low glitch passes, return high is then filtered
    settle(1'b1);
    flt_mode = 2'b01;
    step(2);
    pin_raw = 1'b0;
    step(4);
    check(pin_clean, 1'b0, "R7 glitch passes");
    pin_raw = 1'b1;
    step(20);
    check(pin_clean, 1'b0, "R7 return held");

    // R8: high glitch passes, return low is then filtered
    settle(1'b0);
    flt_mode = 2'b10;
    step(2);
    pin_raw = 1'b1;
    step(4);
    check(pin_clean, 1'b1, "R8 glitch passes");
    pin_raw = 1'b0;
    step(20);
    check(pin_clean, 1'b1, "R8 return held");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule